// File: doc/BRIEF.md
# NAND Page Read Controller

This block is the host side of a read from a small-page NAND device. A client hands it one request: an area selector, a 16-bit page address, an 8-bit start column and a byte count. The controller then drives the flash pins. It writes a single command byte and three address bytes, waits for the ready/busy line to go high, and toggles read-enable once for each byte. Every byte it samples is passed downstream on a valid/ready stream.

A page holds 528 byte positions: 0 to 511 is the main array and 512 to 527 is the spare array. There are three selectors. First half starts at the column given. Second half adds 256 to the column. Spare adds 512 to the low four column bits. A transfer may run past the end of a page. In that case the controller sends no new command: it waits on busy again and carries on in the next page. After the page boundary, a spare transfer continues at position 512 and any other transfer continues at position 0. The second-half pointer therefore lasts for one page only, and every second-half request writes its own command.

Back-pressure: the stream holds one byte. While `dout_valid` is high and `dout_ready` is low, the byte and its last flag stay frozen, and no further read-enable pulse starts. A byte moves on every cycle in which both signals are high. Without back-pressure, a cycle of read-enable takes 2·HALF_CYC clocks plus one clock of gap.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, chip-enable and write-enable and read-enable are high, both latch enables are low, `req_ready` is high and `dout_valid` is low. Chip-enable stays high whenever the controller is idle.
- R2: An accepted request writes exactly one byte with command-latch high. Three bytes with address-latch high follow, in this order: column, page bits 7:0, page bits 15:8. Each byte is valid at the rising edge of write-enable. The two latch enables are never high together, and write-enable goes low only while chip-enable is low.
- R3: `req_area` is encoded as 0 = first half (command 00h, start position = column), 1 = second half (command 01h, start position = 256 + column), 2 or 3 = spare (command 50h, start position = 512 + column bits 3:0). The column byte is sent as given.
- R4: After the address bytes, read-enable stays high through a settle of SETTLE_CYC clocks. It then stays high until ready/busy reads high. Read-enable never falls while ready/busy is low.
- R5: Each read-enable pulse is low for exactly HALF_CYC clocks and is then high for at least HALF_CYC clocks. The byte is sampled at the end of the low phase.
- R6: When a transfer passes position 527, the controller writes no new command and takes one more busy wait with chip-enable held low. It then continues in page+1, at position 512 for spare transfers and at position 0 otherwise.
- R7: Every second-half request writes command 01h, including one that directly follows another second-half request. Its page crossing continues at position 0 of the next page.
- R8: While `dout_valid` is high and `dout_ready` is low, `dout_data` and `dout_last` hold and no read-enable pulse begins. `dout_last` is high only with the final byte of a request.
- R9: After the high phase of the final pulse, chip-enable rises and `xfer_done` pulses for one clock.
- R10: If ready/busy stays low for BUSY_TMO clocks of a busy wait, `err_timeout` pulses for one clock, chip-enable is high, the controller is idle and it emits no bytes.
- R11: A request with a byte count of zero is accepted and pulses `xfer_done` with no write-enable or read-enable activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_area | input | 2 | Area selector (0 first half, 1 second half, 2/3 spare) |
| req_page | input | 16 | Page address |
| req_col | input | 8 | Start column |
| req_len | input | LEN_W | Number of bytes to read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_out | output | 8 | Byte driven to the flash |
| nand_io_oe | output | 1 | Output enable for the I/O bus |
| nand_io_in | input | 8 | Byte from the flash |
| nand_rb | input | 1 | Ready (1) / busy (0) |
| dout_valid | output | 1 | Stream byte valid |
| dout_ready | input | 1 | Stream consumer ready |
| dout_data | output | 8 | Stream byte |
| dout_last | output | 1 | Final byte of the request |
| xfer_done | output | 1 | One-clock pulse at normal completion |
| err_timeout | output | 1 | One-clock pulse on busy timeout |

## Verification
The page-boundary busy wait can coincide with a stalled stream. The final byte of a page can be captured while the consumer refuses it, so the controller has to wait out the device busy period while it still holds that byte. The test provokes this with a spare read that starts at position 527 and keeps `dout_ready` low. It then judges that only one read-enable pulse has happened, that the device went through its second busy period, and that the held byte is stable. After release, the three bytes must arrive in page order under a single command.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WR_LO, S_WR_HI, S_SETTLE, S_WAIT_RB, S_RD_GAP, S_RD_LO, S_RD_HI
  } nrd_state_e;

  localparam logic [7:0] CMD_FIRST  = 8'h00;
  localparam logic [7:0] CMD_SECOND = 8'h01;
  localparam logic [7:0] CMD_SPARE  = 8'h50;

  localparam int PAGE_BYTES  = 528;
  localparam int SECOND_BASE = 256;
  localparam int SPARE_BASE  = 512;
  localparam int POS_W       = $clog2(PAGE_BYTES);
  localparam int WR_BYTES    = 4;
endpackage

// File: rtl/nrd_phase_cnt.sv
module nrd_phase_cnt #(
  parameter int HALF_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  logic [CW-1:0] cnt;

  assign done = run && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || done) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nrd_busy_watch.sv
module nrd_busy_watch #(
  parameter int SETTLE_CYC = 4,
  parameter int BUSY_TMO   = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic settle_en,
  input  logic wait_en,
  input  logic rb,
  output logic settle_done,
  output logic tmo
);
  localparam int MAXC = (SETTLE_CYC > BUSY_TMO) ? SETTLE_CYC : BUSY_TMO;
  localparam int CW   = $clog2(MAXC + 1);
  logic [CW-1:0] cnt;

  assign settle_done = settle_en && (cnt == CW'(SETTLE_CYC - 1));
  assign tmo         = wait_en && !rb && (cnt == CW'(BUSY_TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     cnt <= '0;
    else if (!(settle_en || wait_en) || settle_done) cnt <= '0;
    else if (wait_en && rb)                          cnt <= '0;
    else if (!tmo)                                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nrd_col_track.sv
module nrd_col_track import nrd_pkg::*; #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       area,
  input  logic [7:0]       col,
  input  logic [LEN_W-1:0] len,
  input  logic             adv,
  input  logic             ack_wrap,
  output logic [POS_W-1:0] pos,
  output logic [LEN_W-1:0] remain,
  output logic             wrapped
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PAGE_BYTES - 1);
  logic             spare_q;
  logic [POS_W-1:0] start_pos;

  always_comb begin
    if (area[1])      start_pos = POS_W'(SPARE_BASE) + POS_W'(col[3:0]);
    else if (area[0]) start_pos = POS_W'(SECOND_BASE) + POS_W'(col);
    else              start_pos = POS_W'(col);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      remain  <= '0;
      wrapped <= 1'b0;
      spare_q <= 1'b0;
    end else if (load) begin
      pos     <= start_pos;
      remain  <= len;
      wrapped <= 1'b0;
      spare_q <= area[1];
    end else begin
      if (ack_wrap) wrapped <= 1'b0;
      if (adv) begin
        remain <= remain - 1'b1;
        if (pos == LAST_POS) begin
          pos     <= spare_q ? POS_W'(SPARE_BASE) : '0;
          wrapped <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nrd_out_reg.sv
module nrd_out_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       last_in,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] data,
  output logic       last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
      last  <= last_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader import nrd_pkg::*; #(
  parameter int HALF_CYC   = 3,
  parameter int SETTLE_CYC = 4,
  parameter int BUSY_TMO   = 2000,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_area,
  input  logic [15:0]      req_page,
  input  logic [7:0]       req_col,
  input  logic [LEN_W-1:0] req_len,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rb,
  output logic             dout_valid,
  input  logic             dout_ready,
  output logic [7:0]       dout_data,
  output logic             dout_last,
  output logic             xfer_done,
  output logic             err_timeout
);
  localparam int WI_W = $clog2(WR_BYTES);

  nrd_state_e       state;
  logic [WI_W-1:0]  widx;
  logic [7:0]       cmd_q, col_q;
  logic [15:0]      page_q;
  logic             done_q, err_q;

  logic             ph_run, ph_done;
  logic             settle_done, tmo;
  logic             accept, trk_load, adv, ack_wrap;
  logic [POS_W-1:0] pos;
  logic [LEN_W-1:0] remain;
  logic             wrapped;
  logic             in_wr;

  assign req_ready   = (state == S_IDLE);
  assign accept      = req_ready && req_valid;
  assign trk_load    = accept && (req_len != '0);
  assign ph_run      = (state == S_WR_LO) || (state == S_WR_HI) ||
                       (state == S_RD_LO) || (state == S_RD_HI);
  assign adv         = (state == S_RD_LO) && ph_done;
  assign ack_wrap    = (state == S_RD_HI) && ph_done && wrapped;
  assign in_wr       = (state == S_WR_LO) || (state == S_WR_HI);

  assign nand_ce_n   = (state == S_IDLE);
  assign nand_cle    = in_wr && (widx == '0);
  assign nand_ale    = in_wr && (widx != '0);
  assign nand_we_n   = (state != S_WR_LO);
  assign nand_re_n   = (state != S_RD_LO);
  assign nand_io_oe  = in_wr;
  assign xfer_done   = done_q;
  assign err_timeout = err_q;

  always_comb begin
    case (widx)
      2'd0:    nand_io_out = cmd_q;
      2'd1:    nand_io_out = col_q;
      2'd2:    nand_io_out = page_q[7:0];
      default: nand_io_out = page_q[15:8];
    endcase
  end

  nrd_phase_cnt #(.HALF_CYC(HALF_CYC)) i_phase (
    .clk(clk), .rst_n(rst_n), .run(ph_run), .done(ph_done)
  );

  nrd_busy_watch #(.SETTLE_CYC(SETTLE_CYC), .BUSY_TMO(BUSY_TMO)) i_busy (
    .clk(clk), .rst_n(rst_n),
    .settle_en(state == S_SETTLE), .wait_en(state == S_WAIT_RB),
    .rb(nand_rb), .settle_done(settle_done), .tmo(tmo)
  );

  nrd_col_track #(.LEN_W(LEN_W)) i_track (
    .clk(clk), .rst_n(rst_n), .load(trk_load), .area(req_area),
    .col(req_col), .len(req_len), .adv(adv), .ack_wrap(ack_wrap),
    .pos(pos), .remain(remain), .wrapped(wrapped)
  );

  nrd_out_reg i_out (
    .clk(clk), .rst_n(rst_n), .load(adv), .din(nand_io_in),
    .last_in(remain == LEN_W'(1)), .ready(dout_ready),
    .valid(dout_valid), .data(dout_data), .last(dout_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      widx   <= '0;
      cmd_q  <= '0;
      col_q  <= '0;
      page_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (req_len == '0) begin
              done_q <= 1'b1;
            end else begin
              widx   <= '0;
              col_q  <= req_col;
              page_q <= req_page;
              if (req_area[1])      cmd_q <= CMD_SPARE;
              else if (req_area[0]) cmd_q <= CMD_SECOND;
              else                  cmd_q <= CMD_FIRST;
              state  <= S_WR_LO;
            end
          end
        end
        S_WR_LO: if (ph_done) state <= S_WR_HI;
        S_WR_HI: begin
          if (ph_done) begin
            if (widx == WI_W'(WR_BYTES - 1)) begin
              state <= S_SETTLE;
            end else begin
              widx  <= widx + 1'b1;
              state <= S_WR_LO;
            end
          end
        end
        S_SETTLE: if (settle_done) state <= S_WAIT_RB;
        S_WAIT_RB: begin
          if (nand_rb) begin
            state <= S_RD_GAP;
          end else if (tmo) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_RD_GAP: if (!dout_valid) state <= S_RD_LO;
        S_RD_LO:  if (ph_done) state <= S_RD_HI;
        S_RD_HI: begin
          if (ph_done) begin
            if (remain == '0) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else if (wrapped) begin
              state  <= S_SETTLE;
            end else begin
              state  <= S_RD_GAP;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nrd_checker.sv
module nrd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_rb,
  input logic       dout_valid,
  input logic       dout_ready,
  input logic [7:0] dout_data,
  input logic       dout_last,
  input logic       err_timeout
);
  AST_IDLE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nand_ce_n);                                               // R1
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));                                               // R2
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> !nand_ce_n);                                             // R2
  AST_RE_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) |-> nand_rb);                                          // R4
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data) && $stable(dout_last))); // R8
  AST_NO_RE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) |-> !$past(dout_valid));                              // R8
  AST_TIMEOUT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (nand_ce_n && req_ready));                              // R10
endmodule

bind nand_page_reader nrd_checker i_nrd_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .nand_ce_n(nand_ce_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .nand_rb(nand_rb), .dout_valid(dout_valid),
  .dout_ready(dout_ready), .dout_data(dout_data), .dout_last(dout_last),
  .err_timeout(err_timeout)
);

// File: tb/test_nand_page_reader.sv
module test_nand_page_reader;
  localparam int HALF = 3;
  localparam int BUSY_CYC = 40;
  localparam int TMO = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [1:0]  req_area = '0;
  logic [15:0] req_page = '0;
  logic [7:0]  req_col = '0;
  logic [15:0] req_len = '0;
  logic        sink_ready = 1'b1;
  logic        req_ready, ce_n, cle, ale, we_n, re_n, io_oe;
  logic [7:0]  io_out, io_in, dout_data;
  logic        dout_valid, dout_last, xfer_done, err_timeout;
  logic        m_rb = 1'b1;

  nand_page_reader i_nand_page_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_area(req_area), .req_page(req_page), .req_col(req_col), .req_len(req_len),
    .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n),
    .nand_re_n(re_n), .nand_io_out(io_out), .nand_io_oe(io_oe),
    .nand_io_in(io_in), .nand_rb(m_rb), .dout_valid(dout_valid),
    .dout_ready(sink_ready), .dout_data(dout_data), .dout_last(dout_last),
    .xfer_done(xfer_done), .err_timeout(err_timeout)
  );

  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [7:0] dev_byte(input logic [15:0] pg, input int p);
    return 8'((pg[7:0] * 3) + (p & 255) + ((p >> 8) * 17));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash device model ----------------
  logic [7:0]  wr_log [0:15];
  int          wr_cnt = 0, cmd_cnt = 0, re_falls = 0, busy_periods = 0;
  int          busy_left = 0, addr_i = 0, m_col = 0;
  int          lo_run = 0, hi_run = 0, lo_min = 999, lo_max = 0, hi_min = 999;
  bit          m_stuck = 0, m_spare = 0, re_in_busy = 0, seen_rise = 0;
  logic [7:0]  m_cmd = '0, m_a0 = '0;
  logic [15:0] m_page = '0;
  logic        prev_we = 1'b1, prev_re = 1'b1;

  assign io_in = dev_byte(m_page, m_col);

  always @(negedge clk) begin
    if (!m_rb && !m_stuck) begin
      busy_left--;
      if (busy_left <= 0) m_rb = 1'b1;
    end
    if (!prev_we && we_n && !ce_n) begin
      if (wr_cnt < 16) wr_log[wr_cnt] = io_out;
      wr_cnt++;
      if (cle) begin
        m_cmd = io_out; addr_i = 0; cmd_cnt++;
      end else if (ale) begin
        if (addr_i == 0) m_a0 = io_out;
        else if (addr_i == 1) m_page[7:0] = io_out;
        else begin
          m_page[15:8] = io_out;
          m_spare = (m_cmd == 8'h50);
          if (m_cmd == 8'h50)      m_col = 512 + int'(m_a0[3:0]);
          else if (m_cmd == 8'h01) m_col = 256 + int'(m_a0);
          else                     m_col = int'(m_a0);
          m_rb = 1'b0; busy_left = BUSY_CYC; busy_periods++;
        end
        addr_i++;
      end
    end
    if (prev_re && !re_n) begin
      re_falls++;
      if (!m_rb) re_in_busy = 1;
      if (seen_rise && hi_run < hi_min) hi_min = hi_run;
    end
    if (!re_n) lo_run++; else hi_run++;
    if (!prev_re && re_n) begin
      if (lo_run < lo_min) lo_min = lo_run;
      if (lo_run > lo_max) lo_max = lo_run;
      lo_run = 0; hi_run = 0; seen_rise = 1;
      if (m_col == 527) begin
        m_page = m_page + 1'b1;
        m_col = m_spare ? 512 : 0;
        m_rb = 1'b0; busy_left = BUSY_CYC; busy_periods++;
      end else m_col++;
    end
    prev_we = we_n;
    prev_re = re_n;
  end

  // ---------------- stream collector ----------------
  logic [7:0] rx [0:63];
  bit         rx_last [0:63];
  int         rx_n = 0, done_cnt = 0, err_cnt = 0;

  always @(negedge clk) begin
    if (dout_valid && sink_ready) begin
      if (rx_n < 64) begin rx[rx_n] = dout_data; rx_last[rx_n] = dout_last; end
      rx_n++;
    end
    if (xfer_done) done_cnt++;
    if (err_timeout) err_cnt++;
  end

  task automatic clear_logs();
    wr_cnt = 0; cmd_cnt = 0; re_falls = 0; busy_periods = 0;
    rx_n = 0; done_cnt = 0; err_cnt = 0; re_in_busy = 0;
    lo_min = 999; lo_max = 0; hi_min = 999; seen_rise = 0;
  endtask

  task automatic issue(input logic [1:0] a, input logic [15:0] pg,
                       input logic [7:0] c, input int len);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    req_area = a; req_page = pg; req_col = c; req_len = 16'(len);
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done_cnt != 0 || err_cnt != 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_data(input string req, input logic [1:0] a,
                            input logic [15:0] pg, input logic [7:0] c, input int len);
    int p;
    logic [15:0] cp;
    cp = pg;
    if (a[1]) p = 512 + int'(c[3:0]);
    else if (a[0]) p = 256 + int'(c);
    else p = int'(c);
    check(rx_n == len, req, "byte count", rx_n, len);
    for (int k = 0; k < len && k < 64 && k < rx_n; k++) begin
      check(rx[k] == dev_byte(cp, p), req, $sformatf("byte %0d", k),
            int'(rx[k]), int'(dev_byte(cp, p)));
      check(rx_last[k] == (k == len - 1), "R8", $sformatf("last flag %0d", k),
            int'(rx_last[k]), int'(k == len - 1));
      if (p == 527) begin cp = cp + 1'b1; p = a[1] ? 512 : 0; end
      else p++;
    end
  endtask

  task automatic check_header(input string req, input logic [7:0] cmd,
                              input logic [7:0] c, input logic [15:0] pg);
    check(cmd_cnt == 1, "R2", "command writes", cmd_cnt, 1);
    check(wr_cnt == 4, "R2", "bytes written", wr_cnt, 4);
    check(wr_log[0] == cmd, req, "command byte", int'(wr_log[0]), int'(cmd));
    check(wr_log[1] == c, "R2", "column byte", int'(wr_log[1]), int'(c));
    check(wr_log[2] == pg[7:0], "R2", "page low byte", int'(wr_log[2]), int'(pg[7:0]));
    check(wr_log[3] == pg[15:8], "R2", "page high byte", int'(wr_log[3]), int'(pg[15:8]));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    check(ce_n && we_n && re_n && !cle && !ale, "R1", "pins after reset",
          {ce_n, we_n, re_n, cle, ale}, 5'b11100);
    check(req_ready && !dout_valid, "R1", "ready/valid after reset",
          {req_ready, dout_valid}, 2'b10);
  endtask

  task automatic t_first_half();
    clear_logs();
    issue(2'd0, 16'h0123, 8'd5, 8);
    wait_end();
    check_header("R3", 8'h00, 8'd5, 16'h0123);
    check_data("R3", 2'd0, 16'h0123, 8'd5, 8);
    check(re_in_busy == 0, "R4", "RE fell while busy", int'(re_in_busy), 0);
    check(lo_min == HALF && lo_max == HALF, "R5", "RE low width", lo_max, HALF);
    check(hi_min >= HALF, "R5", "RE high width", hi_min, HALF);
    check(done_cnt == 1 && ce_n, "R9", "done pulse and CE high", done_cnt, 1);
  endtask

  task automatic t_second_twice();
    for (int r = 0; r < 2; r++) begin
      clear_logs();
      issue(2'd1, 16'h0040, 8'd10, 4);
      wait_end();
      check_header("R7", 8'h01, 8'd10, 16'h0040);
      check_data("R7", 2'd1, 16'h0040, 8'd10, 4);
    end
  endtask

  task automatic t_spare_cross();
    clear_logs();
    issue(2'd2, 16'h0200, 8'hF3, 20);
    wait_end();
    check_header("R3", 8'h50, 8'hF3, 16'h0200);
    check_data("R6", 2'd2, 16'h0200, 8'hF3, 20);
    check(busy_periods == 2, "R6", "busy periods", busy_periods, 2);
  endtask

  task automatic t_second_cross();
    clear_logs();
    issue(2'd1, 16'h1FFF, 8'd254, 22);
    wait_end();
    check(cmd_cnt == 1, "R6", "commands across page", cmd_cnt, 1);
    check_data("R7", 2'd1, 16'h1FFF, 8'd254, 22);
    check(busy_periods == 2, "R6", "busy periods", busy_periods, 2);
    check(re_in_busy == 0, "R4", "RE fell while busy", int'(re_in_busy), 0);
  endtask

  task automatic t_stall_cross();
    logic [7:0] held;
    clear_logs();
    @(posedge clk); #1; sink_ready = 1'b0;
    issue(2'd2, 16'h0077, 8'd15, 3);
    repeat (250) @(negedge clk);
    check(re_falls == 1, "R8", "RE pulses while held", re_falls, 1);
    check(dout_valid == 1'b1, "R8", "valid held", int'(dout_valid), 1);
    check(busy_periods == 2, "R6", "busy during stall", busy_periods, 2);
    held = dout_data;
    repeat (5) @(negedge clk);
    check(dout_data == held && dout_data == dev_byte(16'h0077, 527), "R8",
          "held byte", int'(dout_data), int'(dev_byte(16'h0077, 527)));
    @(posedge clk); #1; sink_ready = 1'b1;
    wait_end();
    check(cmd_cnt == 1, "R6", "commands", cmd_cnt, 1);
    check_data("R8", 2'd2, 16'h0077, 8'd15, 3);
  endtask

  task automatic t_zero_len();
    clear_logs();
    issue(2'd0, 16'h0005, 8'd0, 0);
    wait_end();
    check(done_cnt == 1, "R11", "done pulse", done_cnt, 1);
    check(wr_cnt == 0 && re_falls == 0, "R11", "bus activity", wr_cnt + re_falls, 0);
    check(ce_n && rx_n == 0, "R11", "CE high, no data", rx_n, 0);
  endtask

  task automatic t_timeout();
    clear_logs();
    m_stuck = 1;
    issue(2'd0, 16'h0300, 8'd0, 4);
    wait_end();
    check(err_cnt == 1, "R10", "timeout pulse", err_cnt, 1);
    check(done_cnt == 0 && rx_n == 0, "R10", "no data or done", rx_n + done_cnt, 0);
    check(ce_n && req_ready, "R10", "CE high and idle", {ce_n, req_ready}, 2'b11);
    check(re_falls == 0, "R10", "no RE pulses", re_falls, 0);
    m_stuck = 0;
    repeat (BUSY_CYC + 5) @(negedge clk);
    clear_logs();
    issue(2'd0, 16'h0301, 8'd7, 3);
    wait_end();
    check_data("R10", 2'd0, 16'h0301, 8'd7, 3);
  endtask

  bit finished = 0;

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_first_half();
    t_second_twice();
    t_spare_cross();
    t_second_cross();
    t_stall_cross();
    t_zero_len();
    t_timeout();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule